// File: doc/BRIEF.md
# Identification and Byte/Word Read Multiplexer

This block is the read data path that sits between a flash array and its data pins. In normal operation it passes a 16-bit array word to the pins. When the identification mode is active, it substitutes one of several fixed codes. Address bits 6, 1 and 0 choose the code: the maker code, a device code that depends on the boot configuration, or a protect flag for the sector named by the upper address bits.

A bus-width select input chooses between 16-bit and 8-bit operation. In 8-bit mode only the low eight data pins are driven. Pins 8 to 14 float. Pin 15 is read as the least significant (half-word) address, which selects the byte of the array word that appears on the low pins. The block drives data plus one output-enable bit per pin. Chip select and output enable gate all of those enables.

All outputs are registered once, so a pin reflects the inputs sampled at the previous rising clock edge. Array storage and the command decode that enters identification mode are outside this block.

Top module: `idmux_read_path`

## Requirements
- R1: In identification mode with A6=0, A1=0, A0=0 the data reads 0001h in 16-bit mode and 01h on pins 7..0 in 8-bit mode.
- R2: In identification mode with A6=0, A1=0, A0=1 the data reads 220Ch (parameter TOP_BOOT=1) or 220Fh (TOP_BOOT=0) in 16-bit mode, and 0Ch or 0Fh in 8-bit mode, for either value of the pin-15 address.
- R3: In identification mode with A6=0, A1=1, A0=0 the data reads 0001h if the bit of the protect map indexed by address bits [ADDR_W-1:SECT_SHIFT] is 1, else 0000h.
- R4: Outside identification mode in 16-bit mode the array word passes to pins 15..0 unchanged.
- R5: With chip select low, output enable low and width select high (16-bit), all 16 pin enables are 1.
- R6: With width select low (8-bit) and the block enabled, pin enables 7..0 are 1, pin enables 15..8 are 0, and data bits 15..8 read 0.
- R7: In 8-bit mode outside identification mode, pin-15 input 0 puts array bits 7..0 on pins 7..0, and input 1 puts array bits 15..8 there.
- R8: Chip select high or output enable high (active-low inputs) makes all 16 pin enables 0 and data 0.
- R9: Outputs change one clock after their inputs; during reset all pin enables and data are 0.
- R10: In identification mode any other setting of A6, A1, A0 reads 0000h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| id_mode_i | input | 1 | Identification mode active |
| addr_i | input | ADDR_W | Word address from the pins |
| array_data_i | input | 16 | Array word at addr_i |
| prot_map_i | input | 2**(ADDR_W-SECT_SHIFT) | Per-sector protect flags |
| word_mode_i | input | 1 | 1 = 16-bit bus, 0 = 8-bit bus |
| chip_sel_n_i | input | 1 | Active-low chip select |
| out_en_n_i | input | 1 | Active-low output enable |
| dq15_in_i | input | 1 | Pin 15 sensed as input (half-word address in 8-bit mode) |
| dq_o | output | 16 | Data to drive on the pins |
| dq_oe_o | output | 16 | Per-pin output enable |

## Verification
A wrong code selector or boot choice shows as a wrong value on pins 7..0 one clock after the address changes. Because the codes are fixed, such a fault is visible on the first identification read. A stuck width or enable path shows as enable bits set on pins 8..15 in 8-bit mode, or as missing enables, on the very next clock. A swapped byte lane shows only in 8-bit array reads, and only when the two bytes of the word differ.

// File: rtl/idmux_pkg.sv
package idmux_pkg;

  typedef enum logic [2:0] {
    SRC_ARRAY = 3'd0,
    SRC_MAKER = 3'd1,
    SRC_DEVID = 3'd2,
    SRC_PROT  = 3'd3,
    SRC_ZERO  = 3'd4
  } src_e;

  localparam logic [7:0] MAKER_CODE  = 8'h01;
  localparam logic [7:0] DEVID_HIGH  = 8'h22;
  localparam logic [7:0] DEVID_TOP   = 8'h0C;
  localparam logic [7:0] DEVID_BOT   = 8'h0F;

  // Device code; the upper byte is only present on a 16-bit bus
  function automatic logic [15:0] devid_value(input logic top_boot, input logic wide);
    logic [7:0] lo;
    lo = top_boot ? DEVID_TOP : DEVID_BOT;
    return wide ? {DEVID_HIGH, lo} : {8'h00, lo};
  endfunction

  // Byte lane chosen by the half-word address in 8-bit mode
  function automatic logic [7:0] lane_pick(input logic [15:0] w, input logic hi);
    return hi ? w[15:8] : w[7:0];
  endfunction

endpackage

// File: rtl/idmux_src_dec.sv
module idmux_src_dec
  import idmux_pkg::*;
(
  input  logic id_mode_i,
  input  logic a6_i,
  input  logic a1_i,
  input  logic a0_i,
  output src_e src_o
);
  always_comb begin
    if (!id_mode_i) src_o = SRC_ARRAY;
    else if (a6_i) src_o = SRC_ZERO;
    else begin
      unique case ({a1_i, a0_i})
        2'b00:   src_o = SRC_MAKER;
        2'b01:   src_o = SRC_DEVID;
        2'b10:   src_o = SRC_PROT;
        default: src_o = SRC_ZERO;
      endcase
    end
  end
endmodule

// File: rtl/idmux_code_gen.sv
module idmux_code_gen
  import idmux_pkg::*;
#(
  parameter bit TOP_BOOT = 1'b1
) (
  input  src_e        src_i,
  input  logic        wide_i,
  input  logic        hi_lane_i,
  input  logic        prot_bit_i,
  input  logic [15:0] array_i,
  output logic [15:0] data_o
);
  logic [15:0] raw;

  always_comb begin
    unique case (src_i)
      SRC_ARRAY: raw = wide_i ? array_i : {8'h00, lane_pick(array_i, hi_lane_i)};
      SRC_MAKER: raw = {8'h00, MAKER_CODE};
      SRC_DEVID: raw = devid_value(TOP_BOOT, wide_i);
      SRC_PROT:  raw = {15'd0, prot_bit_i};
      default:   raw = 16'h0000;
    endcase
    data_o = wide_i ? raw : {8'h00, raw[7:0]};
  end
endmodule

// File: rtl/idmux_pin_en.sv
module idmux_pin_en #(
  parameter int DQ_W = 16
) (
  input  logic            chip_sel_n_i,
  input  logic            out_en_n_i,
  input  logic            wide_i,
  output logic [DQ_W-1:0] oe_o
);
  localparam int LOW_W = DQ_W / 2;
  logic active;
  assign active = !chip_sel_n_i && !out_en_n_i;

  for (genvar i = 0; i < DQ_W; i++) begin : g_pin
    if (i < LOW_W) begin : g_low
      assign oe_o[i] = active;
    end else begin : g_high
      assign oe_o[i] = active && wide_i;
    end
  end
endmodule

// File: rtl/idmux_read_path.sv
module idmux_read_path
  import idmux_pkg::*;
#(
  parameter int ADDR_W     = 18,
  parameter int SECT_SHIFT = 15,
  parameter bit TOP_BOOT   = 1'b1,
  localparam int SECT_W    = ADDR_W - SECT_SHIFT,
  localparam int NUM_SECT  = 1 << SECT_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                id_mode_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [15:0]         array_data_i,
  input  logic [NUM_SECT-1:0] prot_map_i,
  input  logic                word_mode_i,
  input  logic                chip_sel_n_i,
  input  logic                out_en_n_i,
  input  logic                dq15_in_i,
  output logic [15:0]         dq_o,
  output logic [15:0]         dq_oe_o
);
  localparam int DQ_W = 16;

  src_e              src;
  logic [SECT_W-1:0] sect_idx;
  logic              prot_bit;
  logic [15:0]       data_c;
  logic [DQ_W-1:0]   oe_c;
  logic              hi_lane;

  assign sect_idx = addr_i[ADDR_W-1:SECT_SHIFT];
  assign prot_bit = prot_map_i[sect_idx];
  assign hi_lane  = !word_mode_i && dq15_in_i;

  idmux_src_dec u_dec (
    .id_mode_i (id_mode_i),
    .a6_i      (addr_i[6]),
    .a1_i      (addr_i[1]),
    .a0_i      (addr_i[0]),
    .src_o     (src)
  );

  idmux_code_gen #(.TOP_BOOT(TOP_BOOT)) u_gen (
    .src_i      (src),
    .wide_i     (word_mode_i),
    .hi_lane_i  (hi_lane),
    .prot_bit_i (prot_bit),
    .array_i    (array_data_i),
    .data_o     (data_c)
  );

  idmux_pin_en #(.DQ_W(DQ_W)) u_en (
    .chip_sel_n_i (chip_sel_n_i),
    .out_en_n_i   (out_en_n_i),
    .wide_i       (word_mode_i),
    .oe_o         (oe_c)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dq_o    <= '0;
      dq_oe_o <= '0;
    end else begin
      dq_oe_o <= oe_c;
      dq_o    <= (|oe_c) ? data_c : '0;
    end
  end

  // Checks on the registered pin behaviour
  assert_maker_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (id_mode_i && addr_i[6:0] == 7'd0 && !chip_sel_n_i && !out_en_n_i)
      |=> dq_o == 16'h0001);

  assert_word_drive_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!chip_sel_n_i && !out_en_n_i && word_mode_i) |=> dq_oe_o == 16'hFFFF);

  assert_byte_float_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!word_mode_i) |=> (dq_oe_o[15:8] == 8'h00 && dq_o[15:8] == 8'h00));

  assert_disabled_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (chip_sel_n_i || out_en_n_i) |=> (dq_oe_o == 16'h0000 && dq_o == 16'h0000));

  assert_id_upper_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (id_mode_i && !word_mode_i) |=> dq_o[15:8] == 8'h00);

endmodule

// File: tb/idmux_read_path_bench.sv
module idmux_read_path_bench;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 18;
  localparam int SECT_SHIFT = 15;
  localparam int NSECT = 1 << (ADDR_W - SECT_SHIFT);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic id_mode = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [15:0] arr = 16'h0000;
  logic [NSECT-1:0] pmap = 8'b1010_0100;
  logic wmode = 1'b1;
  logic cs_n = 1'b1;
  logic oe_n = 1'b1;
  logic d15 = 1'b0;
  logic [15:0] dq, dq_oe;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  idmux_read_path #(.ADDR_W(ADDR_W), .SECT_SHIFT(SECT_SHIFT), .TOP_BOOT(1'b1))
  u_idmux_read_path (
    .clk(clk), .rst_n(rst_n), .id_mode_i(id_mode), .addr_i(addr),
    .array_data_i(arr), .prot_map_i(pmap), .word_mode_i(wmode),
    .chip_sel_n_i(cs_n), .out_en_n_i(oe_n), .dq15_in_i(d15),
    .dq_o(dq), .dq_oe_o(dq_oe)
  );

  task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // drive on a falling edge, registered at the next rise, sample at the next fall
  task automatic read(input logic idm, input logic [ADDR_W-1:0] a, input logic [15:0] d,
                      input logic w, input logic hb);
    @(negedge clk);
    id_mode = idm; addr = a; arr = d; wmode = w; d15 = hb; cs_n = 1'b0; oe_n = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_reset;
    @(negedge clk);
    check("R9 reset oe", dq_oe, 16'h0000);
    check("R9 reset dq", dq, 16'h0000);
    rst_n = 1'b1;
  endtask

  task automatic t_maker;
    read(1'b1, 18'h3_0000, 16'hBEEF, 1'b1, 1'b0);
    check("R1 word", dq, 16'h0001);
    read(1'b1, 18'h0_0000, 16'hBEEF, 1'b0, 1'b1);
    check("R1 byte", dq, 16'h0001);
  endtask

  task automatic t_devid;
    read(1'b1, 18'h0_0001, 16'h1234, 1'b1, 1'b0);
    check("R2 word", dq, 16'h220C);
    read(1'b1, 18'h0_0001, 16'h1234, 1'b0, 1'b0);
    check("R2 byte lo", dq, 16'h000C);
    read(1'b1, 18'h0_0001, 16'h1234, 1'b0, 1'b1);
    check("R2 byte hi", dq, 16'h000C);
  endtask

  task automatic t_prot;
    for (int s = 0; s < NSECT; s++) begin
      read(1'b1, ADDR_W'(s << SECT_SHIFT) | 18'h2, 16'hFFFF, 1'b1, 1'b0);
      check("R3 sector", dq, {15'd0, pmap[s]});
    end
  endtask

  task automatic t_other;
    read(1'b1, 18'h0_0003, 16'hFFFF, 1'b1, 1'b0);
    check("R10 a1a0=11", dq, 16'h0000);
    read(1'b1, 18'h0_0040, 16'hFFFF, 1'b1, 1'b0);
    check("R10 a6=1", dq, 16'h0000);
  endtask

  task automatic t_array;
    read(1'b0, 18'h0_0001, 16'hA55A, 1'b1, 1'b0);
    check("R4 pass", dq, 16'hA55A);
    check("R5 oe", dq_oe, 16'hFFFF);
    read(1'b0, 18'h1_2345, 16'h3C96, 1'b1, 1'b1);
    check("R4 pass2", dq, 16'h3C96);
  endtask

  task automatic t_byte;
    read(1'b0, 18'h0_0010, 16'hC3A1, 1'b0, 1'b0);
    check("R7 low lane", dq, 16'h00A1);
    check("R6 oe", dq_oe, 16'h00FF);
    read(1'b0, 18'h0_0010, 16'hC3A1, 1'b0, 1'b1);
    check("R7 high lane", dq, 16'h00C3);
    check("R6 oe hi", dq_oe, 16'h00FF);
  endtask

  task automatic t_disable;
    @(negedge clk);
    id_mode = 1'b0; arr = 16'hFFFF; wmode = 1'b1; cs_n = 1'b1; oe_n = 1'b0;
    @(negedge clk);
    check("R8 cs high oe", dq_oe, 16'h0000);
    check("R8 cs high dq", dq, 16'h0000);
    cs_n = 1'b0; oe_n = 1'b1;
    @(negedge clk);
    check("R8 oe high oe", dq_oe, 16'h0000);
  endtask

  task automatic t_latency;
    @(negedge clk);
    id_mode = 1'b0; wmode = 1'b1; cs_n = 1'b0; oe_n = 1'b0; arr = 16'h1111;
    @(negedge clk);
    arr = 16'h2222;
    #1;
    check("R9 held", dq, 16'h1111);
    @(negedge clk);
    check("R9 next", dq, 16'h2222);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(posedge clk);
        t_reset();
        t_maker();
        t_devid();
        t_prot();
        t_other();
        t_array();
        t_byte();
        t_disable();
        t_latency();
      end
      begin
        repeat (5000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule